// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block makes the timing for a serial audio port. One input clock feeds it. That clock is either the system clock or rising edges seen on an external clock pin. An 8-bit divider turns the input clock into a bit clock with a duty cycle close to half. A frame counter then runs on bit clocks and drives a frame-sync pulse. The length and the active width of that pulse are programmed as value-minus-one fields, so a field value of 31 means a 32-bit frame. In a second mode, one single-bit-clock pulse is sent for each transmit-data load.

Software controls the block through level inputs. One input runs the whole generator and a second input enables frame sync. Frame sync only takes effect while the generator runs. A 2-bit mode input chooses which of the two outputs the block drives: both, frame sync only while clocking from the external pin, or neither. Each of the two outputs has its own polarity inversion. The `bit_strobe` output marks each bit-clock period for the data path beside the block.

Top module: `srgfs_top`

## Requirements
- R1: With divider field D, `bit_strobe` is high for one system-clock cycle once every D+1 input-clock ticks. With the internal source, the tick is every system-clock cycle, so D=3 gives a strobe every 4 cycles and D=0 gives a strobe every cycle.
- R2: The bit clock (`bclk_inv`=0) is high for ceil((D+1)/2) of each D+1 input ticks. It rises in the cycle after a strobe. D=3 gives 2 of 4 and D=4 gives 3 of 5.
- R3: With `fs_periodic`=1, the frame-sync level changes only in the cycle after a strobe. The first strobe after `fs_en` rises starts position 0. Each later strobe advances the position, which wraps after the period field P. The level is active at positions below W+1, where W is the width field.
- R4: When W >= P, the frame sync is active for P positions of every P+1, so each frame keeps one inactive bit clock.
- R5: While `fs_en` is 0, the frame-sync output stays inactive while the bit clock keeps running.
- R6: While `gen_run` is 0, `fs_en` has no effect. No strobes occur, and both the bit clock and the frame sync stay at their inactive levels.
- R7: Clearing `gen_run` and `fs_en` in the same cycle makes both outputs inactive one clock later. No strobe follows.
- R8: With `fs_periodic`=0, a pulse on `tx_load` makes the frame sync active for exactly the one bit clock that starts at the next strobe. With no load, there is no pulse.
- R9: With `mode`=2'b01, the input ticks come from rising edges of `ext_clk`. An edge every 6 cycles with D=1 gives a strobe every 12 cycles.
- R10: `mode` sets the output enables. 2'b10 drives both outputs. 2'b01 drives frame sync only. 2'b00 and 2'b11 drive neither.
- R11: `fs_inv`=1 makes the frame sync active-low, and `bclk_inv`=1 inverts the bit clock. An idle output then sits high.
- R12: During reset, `bclk_out`, `fs_out` and `bit_strobe` are 0 when the inversion inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_run | input | 1 | Runs the divider and bit clock; 0 holds the generator in reset |
| fs_en | input | 1 | Enables frame-sync generation while the generator runs |
| fs_periodic | input | 1 | 1: periodic frame sync; 0: one pulse per transmit load |
| mode | input | 2 | 00 slave, 01 external clock with frame sync driven, 10 full master, 11 as slave |
| div_m1 | input | DIV_W | Divide ratio minus one |
| per_m1 | input | FRM_W | Frame length in bit clocks minus one |
| wid_m1 | input | FRM_W | Frame-sync active width in bit clocks minus one |
| bclk_inv | input | 1 | Inverts the bit-clock output |
| fs_inv | input | 1 | Makes the frame sync active-low |
| ext_clk | input | 1 | External clock pin, used as the source in mode 01 |
| tx_load | input | 1 | Transmit-data load pulse, used when fs_periodic is 0 |
| bclk_out | output | 1 | Bit clock |
| bclk_oe | output | 1 | Output enable for the bit clock |
| fs_out | output | 1 | Frame sync |
| fs_oe | output | 1 | Output enable for the frame sync |
| bit_strobe | output | 1 | One-cycle mark at the end of each bit-clock period |

## Verification
`bit_strobe` is combinational and is due in the same cycle as the input tick that completes a divider period. The bit clock and the frame-sync level are registered. They take their new value in the cycle after the strobe. Gating by `gen_run` and `fs_en` shows one clock after the change. External pin edges reach the divider three system clocks after the pin moves.

Inputs are driven one time unit after a rising edge and outputs are sampled on falling edges. A scoreboard queue holds one expected frame-sync level per strobe. The monitor pops it on the falling edge that follows the strobe's falling edge. Before the driver enables frame sync or pulses a load, it first waits for a falling edge with no strobe. This ensures that the first popped entry belongs to the first strobe the design acts on.

// File: rtl/srgfs_pkg.sv
package srgfs_pkg;

   typedef enum logic [1:0] {
      MODE_SLAVE  = 2'b00,
      MODE_EXTCLK = 2'b01,
      MODE_MASTER = 2'b10,
      MODE_RSVD   = 2'b11
   } port_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 1;
   localparam int unsigned MAX_FIELD_W     = 16;

endpackage

// File: rtl/srgfs_clk_src.sv
module srgfs_clk_src #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_ext,
   input  logic ext_clk,
   output logic src_tick
);
   import srgfs_pkg::*;

   localparam int unsigned SMSB = SYNC_STAGES - 1;

   logic [SMSB:0] sync_q;
   logic          last_q;
   logic          ext_rise;

   generate
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("srgfs_clk_src: SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= ext_clk;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SMSB-1:0], ext_clk};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SMSB];
   end

   assign ext_rise = sync_q[SMSB] & ~last_q;
   assign src_tick = use_ext ? ext_rise : 1'b1;

   AST_EXT_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise |=> !ext_rise);   // R9

endmodule

// File: rtl/srgfs_clk_div.sv
module srgfs_clk_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             src_tick,
   input  logic [DIV_W-1:0] div_m1,
   output logic             bit_tick,
   output logic             bclk_q
);
   import srgfs_pkg::*;

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] cnt_next;
   logic [DIV_W:0]   high_len;
   logic             wrap;

   generate
      if (DIV_W < 1 || DIV_W > MAX_FIELD_W) begin : g_bad_div
         $error("srgfs_clk_div: DIV_W out of range");
      end
   endgenerate

   assign wrap     = (cnt >= div_m1);
   assign cnt_next = wrap ? '0 : cnt + 1'b1;
   assign high_len = ({1'b0, div_m1} + (DIV_W+1)'(2)) >> 1;
   assign bit_tick = run & src_tick & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         bclk_q <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         bclk_q <= 1'b0;
      end else if (src_tick) begin
         cnt    <= cnt_next;
         bclk_q <= ({1'b0, cnt_next} < high_len);
      end
   end

   AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> (cnt == '0));   // R1

   AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!bclk_q && !bit_tick));   // R7

endmodule

// File: rtl/srgfs_frame_gen.sv
module srgfs_frame_gen #(
   parameter int unsigned FRM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_run,
   input  logic             fs_en,
   input  logic             periodic,
   input  logic             bit_tick,
   input  logic             tx_load,
   input  logic [FRM_W-1:0] per_m1,
   input  logic [FRM_W-1:0] wid_m1,
   output logic             fs_act
);
   import srgfs_pkg::*;

   logic [FRM_W-1:0] fpos;
   logic [FRM_W-1:0] fpos_next;
   logic [FRM_W:0]   act_len;
   logic             started;
   logic             pend;
   logic             run_fs;

   generate
      if (FRM_W < 1 || FRM_W > MAX_FIELD_W) begin : g_bad_frm
         $error("srgfs_frame_gen: FRM_W out of range");
      end
   endgenerate

   assign run_fs    = gen_run & fs_en;
   assign act_len   = (wid_m1 < per_m1) ? ({1'b0, wid_m1} + 1'b1) : {1'b0, per_m1};
   assign fpos_next = !started ? '0 : ((fpos >= per_m1) ? '0 : fpos + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fpos <= '0; started <= 1'b0; fs_act <= 1'b0; pend <= 1'b0;
      end else if (!run_fs) begin
         fpos <= '0; started <= 1'b0; fs_act <= 1'b0; pend <= 1'b0;
      end else if (periodic) begin
         pend <= 1'b0;
         if (bit_tick) begin
            fpos    <= fpos_next;
            started <= 1'b1;
            fs_act  <= ({1'b0, fpos_next} < act_len);
         end
      end else begin
         fpos    <= '0;
         started <= 1'b0;
         if (bit_tick) begin
            fs_act <= pend | tx_load;
            pend   <= 1'b0;
         end else begin
            pend <= pend | tx_load;
         end
      end
   end

   AST_FS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_fs |=> !fs_act);   // R5

   AST_FS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && run_fs) |=> ($stable(fs_act) || !run_fs));   // R3

endmodule

// File: rtl/srgfs_top.sv
module srgfs_top #(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned FRM_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_run,
   input  logic             fs_en,
   input  logic             fs_periodic,
   input  logic [1:0]       mode,
   input  logic [DIV_W-1:0] div_m1,
   input  logic [FRM_W-1:0] per_m1,
   input  logic [FRM_W-1:0] wid_m1,
   input  logic             bclk_inv,
   input  logic             fs_inv,
   input  logic             ext_clk,
   input  logic             tx_load,
   output logic             bclk_out,
   output logic             bclk_oe,
   output logic             fs_out,
   output logic             fs_oe,
   output logic             bit_strobe
);
   import srgfs_pkg::*;

   port_mode_e pmode;
   logic       use_ext;
   logic       src_tick;
   logic       bclk_q;
   logic       fs_act;

   assign pmode   = port_mode_e'(mode);
   assign use_ext = (pmode == MODE_EXTCLK);
   assign bclk_oe = (pmode == MODE_MASTER);
   assign fs_oe   = (pmode == MODE_MASTER) || (pmode == MODE_EXTCLK);

   srgfs_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .use_ext(use_ext), .ext_clk(ext_clk),
      .src_tick(src_tick)
   );

   srgfs_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(gen_run), .src_tick(src_tick),
      .div_m1(div_m1), .bit_tick(bit_strobe), .bclk_q(bclk_q)
   );

   srgfs_frame_gen #(.FRM_W(FRM_W)) u_frm (
      .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_en(fs_en),
      .periodic(fs_periodic), .bit_tick(bit_strobe), .tx_load(tx_load),
      .per_m1(per_m1), .wid_m1(wid_m1), .fs_act(fs_act)
   );

   assign bclk_out = bclk_q ^ bclk_inv;
   assign fs_out   = fs_act ^ fs_inv;

   AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00) || (mode == 2'b11)) |-> (!bclk_oe && !fs_oe));   // R10

   AST_NO_STROBE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_run |-> !bit_strobe);   // R6

endmodule

// File: tb/test_srgfs_top.sv
module test_srgfs_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gen_run = 1'b0, fs_en = 1'b0, fs_periodic = 1'b1;
   logic [1:0] mode = 2'b00;
   logic [7:0] div_m1 = 8'd3, per_m1 = 8'd7, wid_m1 = 8'd2;
   logic       bclk_inv = 1'b0, fs_inv = 1'b0, ext_clk = 1'b0, tx_load = 1'b0;
   logic       bclk_out, bclk_oe, fs_out, fs_oe, bit_strobe;

   int checks = 0;
   int failures = 0;
   logic exp_q[$];
   string cur_req = "R3";
   logic prev_strobe = 1'b0;

   always #2 clk = ~clk;

   srgfs_top i_srgfs_top (
      .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_en(fs_en),
      .fs_periodic(fs_periodic), .mode(mode), .div_m1(div_m1),
      .per_m1(per_m1), .wid_m1(wid_m1), .bclk_inv(bclk_inv), .fs_inv(fs_inv),
      .ext_clk(ext_clk), .tx_load(tx_load), .bclk_out(bclk_out),
      .bclk_oe(bclk_oe), .fs_out(fs_out), .fs_oe(fs_oe), .bit_strobe(bit_strobe)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: one expected frame-sync level per strobe, due the cycle after it
   always @(negedge clk) begin
      if (prev_strobe && exp_q.size() != 0) begin
         chk(cur_req, int'(fs_out), int'(exp_q.pop_front()));
      end
      prev_strobe = bit_strobe;
   end

   always begin
      repeat (3) @(posedge clk);
      #1 ext_clk = ~ext_clk;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic sync_idle();
      do @(negedge clk); while (bit_strobe);
      @(posedge clk); #1;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic measure_spacing(input string req, input int exp);
      int n = 0;
      do @(negedge clk); while (!bit_strobe);
      do begin @(negedge clk); n++; end while (!bit_strobe);
      chk(req, n, exp);
   endtask

   task automatic measure_high(input string req, input int win, input int exp);
      int h = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (bclk_out) h++;
      end
      chk(req, h, exp);
   endtask

   task automatic run_periodic(input string req, input int per, input int wid,
                               input int n, input logic inv);
      int act = (wid < per) ? wid + 1 : per;
      fs_en = 1'b0; fs_periodic = 1'b1;
      per_m1 = 8'(per); wid_m1 = 8'(wid);
      step(3);
      cur_req = req;
      sync_idle();
      for (int p = 0; p < n; p++) exp_q.push_back(((p % (per + 1)) < act) ^ inv);
      fs_en = 1'b1;
      drain();
      fs_en = 1'b0;
      step(2);
   endtask

   initial begin
      step(3);
      @(negedge clk);
      chk("R12 bclk_out in reset", int'(bclk_out), 0);
      chk("R12 fs_out in reset", int'(fs_out), 0);
      chk("R12 bit_strobe in reset", int'(bit_strobe), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R10 / R1 / R2: full master, internal clock
      mode = 2'b10; gen_run = 1'b1; div_m1 = 8'd3;
      step(12);
      chk("R10 master bclk_oe", int'(bclk_oe), 1);
      chk("R10 master fs_oe", int'(fs_oe), 1);
      measure_spacing("R1 ratio 4", 4);
      measure_high("R2 duty ratio 4", 20, 10);
      div_m1 = 8'd4; step(12);
      measure_spacing("R1 ratio 5", 5);
      measure_high("R2 duty ratio 5", 25, 15);
      div_m1 = 8'd0; step(4);
      measure_spacing("R1 ratio 1", 1);
      div_m1 = 8'd3; step(8);

      // R5: frame sync disabled
      begin
         int hi = 0;
         for (int i = 0; i < 40; i++) begin @(negedge clk); if (fs_out) hi++; end
         chk("R5 fs inactive with fs_en low", hi, 0);
      end

      // R3 / R4 periodic patterns
      run_periodic("R3 per7 wid2", 7, 2, 24, 1'b0);
      run_periodic("R3 per31 wid15", 31, 15, 64, 1'b0);
      run_periodic("R4 per5 wid9 clamp", 5, 9, 18, 1'b0);
      run_periodic("R4 per5 wid5 clamp", 5, 5, 12, 1'b0);

      // R8 load-triggered frame sync
      fs_periodic = 1'b0; fs_en = 1'b1; step(4);
      begin
         int hi = 0;
         for (int i = 0; i < 20; i++) begin @(negedge clk); if (fs_out) hi++; end
         chk("R8 no pulse without load", hi, 0);
      end
      cur_req = "R8 load pulse";
      sync_idle();
      exp_q.push_back(1'b1); exp_q.push_back(1'b0); exp_q.push_back(1'b0);
      tx_load = 1'b1;
      step(1);
      tx_load = 1'b0;
      drain();
      fs_en = 1'b0; step(2);

      // R11 polarity
      fs_inv = 1'b1; step(1);
      @(negedge clk);
      chk("R11 fs idle high when inverted", int'(fs_out), 1);
      run_periodic("R11 inverted per3 wid0", 3, 0, 12, 1'b1);
      fs_inv = 1'b0;

      // R7 stop both together while active
      per_m1 = 8'd7; wid_m1 = 8'd6; fs_periodic = 1'b1; fs_en = 1'b1;
      step(40);
      do @(negedge clk); while (!(fs_out && bclk_out));
      @(posedge clk); #1 gen_run = 1'b0; fs_en = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R7 bclk inactive after stop", int'(bclk_out), 0);
      chk("R7 fs inactive after stop", int'(fs_out), 0);
      begin
         int s = 0;
         for (int i = 0; i < 20; i++) begin @(negedge clk); if (bit_strobe) s++; end
         chk("R7 no strobe after stop", s, 0);
      end

      // R6 fs_en ignored while generator held
      #1 fs_en = 1'b1;
      begin
         int s = 0, f = 0, b = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bit_strobe) s++;
            if (fs_out) f++;
            if (bclk_out) b++;
         end
         chk("R6 no strobe while held", s, 0);
         chk("R6 fs inactive while held", f, 0);
         chk("R6 bclk low while held", b, 0);
      end
      bclk_inv = 1'b1; step(1);
      @(negedge clk);
      chk("R11 bclk idle high when inverted", int'(bclk_out), 1);
      bclk_inv = 1'b0; fs_en = 1'b0;

      // R9 / R10 external source mode
      step(1);
      mode = 2'b01; div_m1 = 8'd1; gen_run = 1'b1;
      step(40);
      chk("R10 extclk bclk_oe", int'(bclk_oe), 0);
      chk("R10 extclk fs_oe", int'(fs_oe), 1);
      measure_spacing("R9 external ratio 2", 12);
      step(1);
      mode = 2'b00; step(1);
      chk("R10 slave bclk_oe", int'(bclk_oe), 0);
      chk("R10 slave fs_oe", int'(fs_oe), 0);
      mode = 2'b11; step(1);
      chk("R10 reserved bclk_oe", int'(bclk_oe), 0);
      chk("R10 reserved fs_oe", int'(fs_oe), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule